// File: doc/BRIEF.md
# 8-bit ALU with condition flags

This is a purely combinational arithmetic and logic unit for an 8-bit accumulator machine. Each cycle the surrounding datapath presents two byte operands, a five-bit operation code and the current condition flags. The unit returns the byte result and a new flag vector. It also returns two write enables: one for the result and a five-bit mask that marks which flags the operation updates.

The operations are:

- Two-operand arithmetic: add, add with carry, subtract, subtract with borrow and compare.
- Two-operand logic: AND, OR, XOR and bit test.
- Shifts and rotates of operand A: arithmetic right, logical right, left, and rotate left or right through carry.
- Other unary operations on operand A: increment, decrement, clear, complement, negate and nibble swap.

Compare and bit test produce a result, but they do not request that it be written. A flag that an operation does not update is passed from the flag input to the flag output unchanged. The half-carry flag of the add operations is the carry out of bit 4, which is the carry into bit 5.

Top module: `alu8_flags`

## Requirements
- R1: Operation codes are 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CMP, 5 AND, 6 OR, 7 XOR, 8 BIT, 9 ASR, 10 LSR, 11 LSL, 12 ROL, 13 ROR, 14 INC, 15 DEC, 16 CLR, 17 COM, 18 NEG and 19 SWAP.
  - ADD returns A+B and ADC returns A+B+C, both modulo 256, and both write all five flags.
  - C is the carry out of bit 7.
  - H is the carry out of bit 4.
  - V is set when both operands have the same sign and the result's sign differs from it.
- R2: SUB returns A-B, and SBC and CMP also compute a difference: SBC returns A-B-C and CMP computes A-B.
  - C is set when the unsigned A is less than B plus the subtracted carry.
  - V is signed overflow of the difference.
  - H is not written, and N and Z follow the difference.
  - CMP places the difference on the result but drives the result write enable low.
- R3: AND, OR, XOR and BIT (BIT computes A AND B) clear V, update N and Z, and leave C and H unwritten. BIT does not request the result write.
- R4: Each shift or rotate loads C with the bit shifted out and sets V to the new C XOR the new N; H is not written.
  - ASR keeps bit 7.
  - LSR inserts 0 at bit 7, and LSL inserts 0 at bit 0.
  - ROL inserts the incoming C at bit 0, and ROR inserts it at bit 7.
- R5: INC returns A+1 and sets V when the result is 0x80. DEC returns A-1 and sets V when the result is 0x7F. Both leave C and H unwritten.
- R6: NEG returns 0-A. It sets V when the result is 0x80, sets C whenever the result is nonzero, and does not write H.
- R7: CLR returns 0x00 with V=0, N=0 and Z=1. COM returns NOT A with V=0 and C=1. Neither writes H.
- R8: SWAP exchanges bits [7:4] with bits [3:0], writes the result and writes no flag.
- R9: The flag vector is ordered bit 4 V, bit 3 H, bit 2 N, bit 1 Z, bit 0 C.
  - For every operation that writes flags, N equals result bit 7 and Z is set exactly when the result is 0x00.
  - Every flag whose mask bit is 0 leaves the unit equal to its input value.
- R10: Operation codes 20 to 31 have no effect. They write neither the result nor any flag, the result output equals A, and the flag output equals the flag input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Operand A (accumulator side, source of unary ops) |
| b_i | input | 8 | Operand B |
| flg_i | input | 5 | Incoming flags {V,H,N,Z,C} |
| res_o | output | 8 | Result byte |
| res_we_o | output | 1 | Result write request |
| flg_o | output | 5 | Outgoing flags {V,H,N,Z,C} |
| flg_we_o | output | 5 | Per-flag write mask, same bit order |

## Verification
Random operands, operation codes over the full 0 to 31 range and random incoming flags probe every operation. Random incoming flags show whether unwritten flags pass through untouched, and whether ADC, SBC, ROL and ROR actually consume the incoming carry.

Directed cases isolate the quirky edges:

- A 0x0F+0x01 add separates the carry-out-of-bit-4 half carry from a conventional nibble carry.
- 0x7F+0x01 and 0x80-0x01 separate signed overflow from unsigned carry.
- INC of 0x7F, DEC of 0x80 and NEG of 0x80 and 0x00 hit the exact V and C trigger values.
- Unused codes show that nothing is written.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic [4:0] op_i,
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  input  logic [4:0] flg_i,
  output logic [7:0] res_o,
  output logic       res_we_o,
  output logic [4:0] flg_o,
  output logic [4:0] flg_we_o
);

  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7;
  localparam logic [4:0] OP_BIT = 5'd8,  OP_ASR = 5'd9,  OP_LSR = 5'd10, OP_LSL = 5'd11;
  localparam logic [4:0] OP_ROL = 5'd12, OP_ROR = 5'd13, OP_INC = 5'd14, OP_DEC = 5'd15;
  localparam logic [4:0] OP_CLR = 5'd16, OP_COM = 5'd17, OP_NEG = 5'd18, OP_SWP = 5'd19;
  localparam int FV = 4, FH = 3, FN = 2, FZ = 1, FC = 0;

  logic       cy, add_ci, sub_ci, add_v, sub_v, is_shift;
  logic [7:0] sum, dif, gen, brw;
  logic [7:0] r;
  logic       w;
  logic [4:0] f, m;

  assign cy       = flg_i[FC];
  assign add_ci   = (op_i == OP_ADC) & cy;
  assign sub_ci   = (op_i == OP_SBC) & cy;
  assign sum      = a_i + b_i + {7'd0, add_ci};
  assign dif      = a_i - b_i - {7'd0, sub_ci};
  assign gen      = (a_i & b_i) | (b_i & ~sum) | (~sum & a_i);
  assign brw      = (~a_i & b_i) | (b_i & dif) | (dif & ~a_i);
  assign add_v    = (a_i[7] & b_i[7] & ~sum[7]) | (~a_i[7] & ~b_i[7] & sum[7]);
  assign sub_v    = (a_i[7] & ~b_i[7] & ~dif[7]) | (~a_i[7] & b_i[7] & dif[7]);
  assign is_shift = (op_i >= OP_ASR) && (op_i <= OP_ROR);

  always_comb begin
    r = a_i;
    w = 1'b0;
    f = flg_i;
    m = 5'b00000;
    case (op_i)
      OP_ADD, OP_ADC: begin
        r = sum; w = 1'b1; m = 5'b11111;
        f[FV] = add_v; f[FH] = gen[4]; f[FC] = gen[7];
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        r = dif; w = (op_i != OP_CMP); m = 5'b10111;
        f[FV] = sub_v; f[FC] = brw[7];
      end
      OP_AND, OP_BIT: begin
        r = a_i & b_i; w = (op_i != OP_BIT); m = 5'b10110; f[FV] = 1'b0;
      end
      OP_OR:  begin r = a_i | b_i; w = 1'b1; m = 5'b10110; f[FV] = 1'b0; end
      OP_XOR: begin r = a_i ^ b_i; w = 1'b1; m = 5'b10110; f[FV] = 1'b0; end
      OP_ASR: begin r = {a_i[7], a_i[7:1]}; w = 1'b1; m = 5'b10111; f[FC] = a_i[0]; end
      OP_LSR: begin r = {1'b0, a_i[7:1]};   w = 1'b1; m = 5'b10111; f[FC] = a_i[0]; end
      OP_LSL: begin r = {a_i[6:0], 1'b0};   w = 1'b1; m = 5'b10111; f[FC] = a_i[7]; end
      OP_ROL: begin r = {a_i[6:0], cy};     w = 1'b1; m = 5'b10111; f[FC] = a_i[7]; end
      OP_ROR: begin r = {cy, a_i[7:1]};     w = 1'b1; m = 5'b10111; f[FC] = a_i[0]; end
      OP_INC: begin r = a_i + 8'd1; w = 1'b1; m = 5'b10110; f[FV] = (r == 8'h80); end
      OP_DEC: begin r = a_i - 8'd1; w = 1'b1; m = 5'b10110; f[FV] = (r == 8'h7F); end
      OP_CLR: begin r = 8'h00; w = 1'b1; m = 5'b10110; f[FV] = 1'b0; end
      OP_COM: begin r = ~a_i;  w = 1'b1; m = 5'b10111; f[FV] = 1'b0; f[FC] = 1'b1; end
      OP_NEG: begin
        r = 8'h00 - a_i; w = 1'b1; m = 5'b10111;
        f[FV] = (r == 8'h80); f[FC] = (r != 8'h00);
      end
      OP_SWP: begin r = {a_i[3:0], a_i[7:4]}; w = 1'b1; end
      default: ;
    endcase
    if (m[FN]) f[FN] = r[7];
    if (m[FZ]) f[FZ] = (r == 8'h00);
    if (is_shift) f[FV] = f[FC] ^ f[FN];
  end

  assign res_o    = r;
  assign res_we_o = w;
  assign flg_o    = f;
  assign flg_we_o = m;

  always_comb begin
    AST_N_SIGN: assert (!flg_we_o[FN] || flg_o[FN] == res_o[7]); // R9
    AST_Z_ZERO: assert (!flg_we_o[FZ] || flg_o[FZ] == (res_o == 8'h00)); // R9
    AST_HOLD_UNMASKED: assert (((flg_o ^ flg_i) & ~flg_we_o) == 5'b00000); // R9
    AST_SHIFT_V: assert (!is_shift || flg_o[FV] == (flg_o[FC] ^ flg_o[FN])); // R4
    AST_CMP_NO_WRITE: assert (op_i != OP_CMP || !res_we_o); // R2
    AST_BIT_NO_WRITE: assert (op_i != OP_BIT || !res_we_o); // R3
    AST_NEG_CARRY: assert (op_i != OP_NEG || flg_o[FC] == (a_i != 8'h00)); // R6
    AST_SWAP_QUIET: assert (op_i != OP_SWP || (flg_we_o == 5'b00000 && res_we_o)); // R8
    AST_IDLE_CODE: assert (op_i <= OP_SWP || (!res_we_o && flg_we_o == 5'b00000 && res_o == a_i)); // R10
  end

endmodule

// File: tb/alu8_flags_bench.sv
module alu8_flags_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op  = 5'd31;
  logic [7:0] a   = 8'h00;
  logic [7:0] b   = 8'h00;
  logic [4:0] fi  = 5'b00000;
  logic [7:0] res;
  logic       rwe;
  logic [4:0] fo, fwe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu8_flags u_alu8_flags (
    .op_i(op), .a_i(a), .b_i(b), .flg_i(fi),
    .res_o(res), .res_we_o(rwe), .flg_o(fo), .flg_we_o(fwe)
  );

  function automatic int sgn(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  function automatic string req_of(input int o);
    if (o <= 1) return "R1";
    if (o <= 4) return "R2";
    if (o <= 8) return "R3";
    if (o <= 13) return "R4";
    if (o <= 15) return "R5";
    if (o == 18) return "R6";
    if (o <= 17) return "R7";
    if (o == 19) return "R8";
    return "R10";
  endfunction

  // expected {res[18:11], we[10], flags[9:5], mask[4:0]}
  function automatic logic [18:0] model(input int o, input int x, input int y, input logic [4:0] f);
    int r, ci, s, d;
    logic w;
    logic [4:0] q, m;
    logic c;
    c = f[0]; q = f; m = 5'b00000; w = 1'b1; r = x;
    case (o)
      0, 1: begin
        ci = (o == 1) ? int'(c) : 0;
        s = x + y + ci; r = s & 255; m = 5'b11111;
        q[0] = (s > 255);
        q[3] = (((x & 31) + (y & 31) + ci) > 31);
        s = sgn(x) + sgn(y) + ci; q[4] = (s > 127) || (s < -128);
      end
      2, 3, 4: begin
        ci = (o == 3) ? int'(c) : 0;
        d = x - y - ci; r = d & 255; m = 5'b10111; w = (o != 4);
        q[0] = (d < 0);
        s = sgn(x) - sgn(y) - ci; q[4] = (s > 127) || (s < -128);
      end
      5, 8: begin r = x & y; m = 5'b10110; q[4] = 1'b0; w = (o != 8); end
      6:    begin r = x | y; m = 5'b10110; q[4] = 1'b0; end
      7:    begin r = x ^ y; m = 5'b10110; q[4] = 1'b0; end
      9:    begin r = (x >> 1) | (x & 128); q[0] = x[0]; m = 5'b10111; end
      10:   begin r = x >> 1; q[0] = x[0]; m = 5'b10111; end
      11:   begin r = (x << 1) & 255; q[0] = (x >= 128); m = 5'b10111; end
      12:   begin r = ((x << 1) | int'(c)) & 255; q[0] = (x >= 128); m = 5'b10111; end
      13:   begin r = (x >> 1) | (int'(c) << 7); q[0] = x[0]; m = 5'b10111; end
      14:   begin r = (x + 1) & 255; q[4] = (r == 128); m = 5'b10110; end
      15:   begin r = (x + 255) & 255; q[4] = (r == 127); m = 5'b10110; end
      16:   begin r = 0; q[4] = 1'b0; m = 5'b10110; end
      17:   begin r = 255 - x; q[4] = 1'b0; q[0] = 1'b1; m = 5'b10111; end
      18:   begin r = (256 - x) & 255; q[4] = (r == 128); q[0] = (r != 0); m = 5'b10111; end
      19:   begin r = ((x & 15) << 4) | (x >> 4); end
      default: begin w = 1'b0; r = x; end
    endcase
    if (m[2]) q[2] = (r >= 128);
    if (m[1]) q[1] = (r == 0);
    if (o >= 9 && o <= 13) q[4] = q[0] ^ q[2];
    return {r[7:0], w, q, m};
  endfunction

  task automatic run(input int o, input int x, input int y, input logic [4:0] f);
    logic [18:0] exp_v, got;
    @(negedge clk);
    op = o[4:0]; a = x[7:0]; b = y[7:0]; fi = f;
    #2;
    exp_v = model(o, x, y, f);
    got = {res, rwe, fo, fwe};
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h b=%02h fi=%05b got res=%02h we=%0b fl=%05b mk=%05b exp res=%02h we=%0b fl=%05b mk=%05b R9",
               req_of(o), o, x, y, f, got[18:11], got[10], got[9:5], got[4:0],
               exp_v[18:11], exp_v[10], exp_v[9:5], exp_v[4:0]);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    run(31, 8'h5A, 8'h11, 5'b10101);   // R10 idle code after reset
    run(0, 8'h7F, 8'h01, 5'b00000);    // R1 V and H set
    run(0, 8'h0F, 8'h01, 5'b00000);    // R1 H is carry out of bit 4: clear
    run(1, 8'hFF, 8'h00, 5'b00001);    // R1 ADC wraps, C and Z
    run(2, 8'h80, 8'h01, 5'b01000);    // R2 V set, H kept
    run(3, 8'h00, 8'h00, 5'b00001);    // R2 SBC borrow
    run(4, 8'h42, 8'h42, 5'b00000);    // R2 CMP equal, no write
    run(8, 8'hF0, 8'h0F, 5'b11001);    // R3 BIT zero, no write
    run(9, 8'h81, 8'h00, 5'b00000);    // R4 ASR keeps sign
    run(12, 8'h80, 8'h00, 5'b00001);   // R4 ROL old C in
    run(13, 8'h01, 8'h00, 5'b00001);   // R4 ROR old C in
    run(14, 8'h7F, 8'h00, 5'b00001);   // R5 INC to 0x80
    run(15, 8'h80, 8'h00, 5'b01000);   // R5 DEC to 0x7F
    run(18, 8'h80, 8'h00, 5'b00000);   // R6 NEG 0x80
    run(18, 8'h00, 8'h00, 5'b11111);   // R6 NEG zero, C clear
    run(16, 8'hAA, 8'h00, 5'b11101);   // R7 CLR
    run(17, 8'hFF, 8'h00, 5'b10000);   // R7 COM
    run(19, 8'hA5, 8'h00, 5'b10101);   // R8 SWAP, flags untouched
    run(25, 8'h33, 8'hCC, 5'b01010);   // R10 unused code
    for (int i = 0; i < 4000; i++)     // R9 over all codes
      run(int'($urandom_range(31, 0)), int'($urandom_range(255, 0)),
          int'($urandom_range(255, 0)), 5'($urandom_range(31, 0)));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule